// File: doc/BRIEF.md
# Programmable Input Toggle Generator

This block makes a square wave on one selected bit of an eight-bit (parameterized) input port byte. The high phase and the low phase each have their own length, counted in bus cycles, where one bus cycle is a fixed number of core clocks (four by default). After a programmed number of transitions the generator stops on its own. Each transition takes the current port byte, replaces only the bit named by a one-hot mask with the new generator level, and presents the merged byte with a one-cycle write strobe. A port-input register downstream takes that byte.

Control is by single-cycle pulses. A start pulse captures the timing, the repeat count and the mask, and cancels any interval in progress. It then begins the first interval, whose length follows the generator's present level. A clear pulse stops the generator at once. When both arrive in the same cycle, clear wins. The generator level survives start and clear, so a later run continues from where the last one stopped.

Top module: `toggle_gen`

## Requirements
- R1: After reset, `port_out_o` is 0, `port_we_o` is 0, `active_o` is 0 and `level_o` is 0.
- R2: An accepted start pulse sets `active_o` in the next cycle. If the start is sampled at clock edge s, the first transition is registered at edge s + DIV*T, where T is the low time when `level_o` is 0 and the high time when it is 1.
- R3: A transition inverts `level_o`. For one cycle it drives `port_we_o` high with `port_out_o` equal to the `port_in_i` byte of the transition cycle, in which the single mask bit is replaced by the new level.
- R4: After a transition, the next interval is the high time if the new level is 1, and the low time if it is 0, again multiplied by DIV clocks.
- R5: With repeat count N, exactly N+1 transitions occur, and then `active_o` falls in the cycle after the last one.
- R6: A high or low time of 0 acts as one bus cycle.
- R7: A clear pulse drops `active_o` in the next cycle and cancels all further transitions. `level_o` keeps its value.
- R8: When start and clear are both high in the same cycle, the start is ignored and the generator is idle afterwards.
- R9: A start while a run is active discards the pending interval. Timing restarts from the new start edge using the new settings.
- R10: `port_out_o` changes only in a cycle where `port_we_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse: load settings and begin a run |
| clear_i | input | 1 | One-cycle pulse: stop the run and zero the remaining count |
| high_time_i | input | CNT_W | Bus cycles spent at level 1 |
| low_time_i | input | CNT_W | Bus cycles spent at level 0 |
| repeat_i | input | REP_W | Transitions after the first one |
| bit_mask_i | input | PORT_W | One-hot selection of the driven port bit |
| port_in_i | input | PORT_W | Current port byte, merged at each transition |
| port_out_o | output | PORT_W | Merged port byte from the last transition |
| port_we_o | output | 1 | One-cycle strobe that marks a new merged byte |
| level_o | output | 1 | Present generator level |
| active_o | output | 1 | A run is in progress |

## Verification
The bench builds the block with DIV=2, CNT_W=8, REP_W=8 and PORT_W=8. The short bus cycle keeps every run to a few dozen clocks. This brings a full sweep within reach: high times 0 to 3, low times 0, 1 and 3, and repeat counts 0 to 3, with the mask walking across every port bit. Each sweep point covers clamping and odd/even transition counts, and each run starts from the level the previous run left behind. Because DIV is not 1, a missing or misaligned prescaler shows up as wrong transition edges.

// File: rtl/tg_pkg.sv
package tg_pkg;
  typedef enum logic {
    TG_IDLE = 1'b0,
    TG_RUN  = 1'b1
  } tg_state_e;
endpackage

// File: rtl/tg_prescaler.sv
module tg_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  assign tick = (phase_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          phase_q <= '0;
    else if (restart)    phase_q <= '0;
    else if (tick)       phase_q <= '0;
    else                 phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/tg_interval_counter.sv
module tg_interval_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cancel,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] remain_q;

  assign expire = tick && (remain_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          remain_q <= '0;
    else if (cancel)                     remain_q <= '0;
    else if (load)                       remain_q <= load_val;
    else if (tick && remain_q != '0)     remain_q <= remain_q - 1'b1;
  end
endmodule

// File: rtl/tg_sequencer.sv
module tg_sequencer
  import tg_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int CNT_W  = 32,
  parameter int REP_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              start_acc,
  input  logic              expire,
  input  logic [CNT_W-1:0]  hi_cl,
  input  logic [CNT_W-1:0]  lo_cl,
  input  logic [REP_W-1:0]  rep_i,
  input  logic [PORT_W-1:0] mask_i,
  input  logic [PORT_W-1:0] port_in_i,
  output logic              level,
  output logic              active,
  output logic              reload,
  output logic [CNT_W-1:0]  hi_q,
  output logic [CNT_W-1:0]  lo_q,
  output logic [PORT_W-1:0] mask_q,
  output logic [PORT_W-1:0] port_out,
  output logic              port_we
);
  tg_state_e        state_q;
  logic [REP_W-1:0] rep_q;

  function automatic logic [PORT_W-1:0] merge_bit(input logic [PORT_W-1:0] base,
                                                  input logic [PORT_W-1:0] m,
                                                  input logic lvl);
    return (base & ~m) | (lvl ? m : '0);
  endfunction

  assign active = (state_q == TG_RUN);
  assign reload = expire && (rep_q != '0) && !clear_i && !start_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= TG_IDLE;
      rep_q    <= '0;
      level    <= 1'b0;
      hi_q     <= '0;
      lo_q     <= '0;
      mask_q   <= '0;
      port_out <= '0;
      port_we  <= 1'b0;
    end else begin
      port_we <= 1'b0;
      if (clear_i) begin
        state_q <= TG_IDLE;
        rep_q   <= '0;
      end else if (start_acc) begin
        state_q <= TG_RUN;
        rep_q   <= rep_i;
        hi_q    <= hi_cl;
        lo_q    <= lo_cl;
        mask_q  <= mask_i;
      end else if (expire) begin
        level    <= ~level;
        port_out <= merge_bit(port_in_i, mask_q, ~level);
        port_we  <= 1'b1;
        if (rep_q == '0) state_q <= TG_IDLE;
        else             rep_q   <= rep_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/toggle_gen.sv
module toggle_gen #(
  parameter int PORT_W = 8,
  parameter int CNT_W  = 32,
  parameter int REP_W  = 32,
  parameter int DIV    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              clear_i,
  input  logic [CNT_W-1:0]  high_time_i,
  input  logic [CNT_W-1:0]  low_time_i,
  input  logic [REP_W-1:0]  repeat_i,
  input  logic [PORT_W-1:0] bit_mask_i,
  input  logic [PORT_W-1:0] port_in_i,
  output logic [PORT_W-1:0] port_out_o,
  output logic              port_we_o,
  output logic              level_o,
  output logic              active_o
);
  function automatic logic [CNT_W-1:0] clamp_iv(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  function automatic logic [CNT_W-1:0] pick_iv(input logic lvl,
                                              input logic [CNT_W-1:0] hi,
                                              input logic [CNT_W-1:0] lo);
    return lvl ? hi : lo;
  endfunction

  logic              start_acc_w;
  logic              tick_w;
  logic              expire_w;
  logic              reload_w;
  logic              load_w;
  logic [CNT_W-1:0]  hi_cl_w, lo_cl_w;
  logic [CNT_W-1:0]  hi_q_w, lo_q_w;
  logic [CNT_W-1:0]  load_val_w;
  logic [PORT_W-1:0] mask_q_w;

  assign start_acc_w = start_i && !clear_i;
  assign hi_cl_w     = clamp_iv(high_time_i);
  assign lo_cl_w     = clamp_iv(low_time_i);
  assign load_w      = start_acc_w || reload_w;
  assign load_val_w  = start_acc_w ? pick_iv(level_o, hi_cl_w, lo_cl_w)
                                   : pick_iv(~level_o, hi_q_w, lo_q_w);

  tg_prescaler #(.DIV(DIV)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (start_acc_w),
    .tick    (tick_w)
  );

  tg_interval_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .cancel   (clear_i),
    .load     (load_w),
    .load_val (load_val_w),
    .tick     (tick_w),
    .expire   (expire_w)
  );

  tg_sequencer #(.PORT_W(PORT_W), .CNT_W(CNT_W), .REP_W(REP_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (clear_i),
    .start_acc (start_acc_w),
    .expire    (expire_w),
    .hi_cl     (hi_cl_w),
    .lo_cl     (lo_cl_w),
    .rep_i     (repeat_i),
    .mask_i    (bit_mask_i),
    .port_in_i (port_in_i),
    .level     (level_o),
    .active    (active_o),
    .reload    (reload_w),
    .hi_q      (hi_q_w),
    .lo_q      (lo_q_w),
    .mask_q    (mask_q_w),
    .port_out  (port_out_o),
    .port_we   (port_we_o)
  );
endmodule

// File: rtl/tg_checker.sv
module tg_checker #(
  parameter int PORT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              clear_i,
  input logic              expire,
  input logic              active_o,
  input logic              level_o,
  input logic              port_we_o,
  input logic [PORT_W-1:0] port_out_o,
  input logic [PORT_W-1:0] port_in_i,
  input logic [PORT_W-1:0] mask_q
);
  p_start_runs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !clear_i) |=> active_o);

  p_keep_others_r3: assert property (@(posedge clk) disable iff (!rst_n)
    port_we_o |-> ((port_out_o & ~mask_q) == ($past(port_in_i) & ~mask_q)));

  p_level_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    port_we_o |-> (((port_out_o & mask_q) != '0) == level_o));

  p_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !clear_i && !start_i) |=> (level_o != $past(level_o)));

  p_we_from_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    port_we_o |-> $past(active_o));

  p_clear_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (!active_o && !port_we_o));

  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && start_i) |=> !active_o);

  p_quiet_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !port_we_o |-> $stable(port_out_o));
endmodule

bind toggle_gen tg_checker #(.PORT_W(PORT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .clear_i    (clear_i),
  .expire     (expire_w),
  .active_o   (active_o),
  .level_o    (level_o),
  .port_we_o  (port_we_o),
  .port_out_o (port_out_o),
  .port_in_i  (port_in_i),
  .mask_q     (mask_q_w)
);

// File: tb/tb_toggle_gen.sv
module tb_toggle_gen;
  localparam int CLK_P = 10;
  localparam int Q     = 2;
  localparam int DIV   = 2;
  localparam int PW    = 8;
  localparam int CW    = 8;
  localparam int RW    = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          clear_i = 1'b0;
  logic [CW-1:0] high_time_i = '0;
  logic [CW-1:0] low_time_i = '0;
  logic [RW-1:0] repeat_i = '0;
  logic [PW-1:0] bit_mask_i = 8'h01;
  logic [PW-1:0] port_in_i = '0;
  logic [PW-1:0] port_out_o;
  logic          port_we_o;
  logic          level_o;
  logic          active_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int nrec = 0;
  int rec_cyc [256];
  logic [PW-1:0] rec_port [256];
  logic rec_lvl [256];
  logic lvl_m = 1'b0;

  toggle_gen #(.PORT_W(PW), .CNT_W(CW), .REP_W(RW), .DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .clear_i(clear_i),
    .high_time_i(high_time_i), .low_time_i(low_time_i), .repeat_i(repeat_i),
    .bit_mask_i(bit_mask_i), .port_in_i(port_in_i), .port_out_o(port_out_o),
    .port_we_o(port_we_o), .level_o(level_o), .active_o(active_o)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  always @(negedge clk) begin
    if (rst_n && port_we_o) begin
      if (nrec < 256) begin
        rec_cyc[nrec]  = cyc;
        rec_port[nrec] = port_out_o;
        rec_lvl[nrec]  = level_o;
      end
      nrec = nrec + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic pulse_start(input int hi, input int lo, input int rep,
                             input int midx, input logic [PW-1:0] pin,
                             output int base, output int s);
    @(posedge clk); #Q;
    high_time_i = CW'(hi);
    low_time_i  = CW'(lo);
    repeat_i    = RW'(rep);
    bit_mask_i  = PW'(1 << midx);
    port_in_i   = pin;
    start_i     = 1'b1;
    base        = nrec;
    s           = cyc + 1;
    @(posedge clk); #Q;
    start_i     = 1'b0;
  endtask

  task automatic run_cfg(input int hi, input int lo, input int rep,
                         input int midx, input logic [PW-1:0] pin);
    int base, s, t, iv;
    logic l;
    logic [PW-1:0] m, ep;
    pulse_start(hi, lo, rep, midx, pin, base, s);
    m = PW'(1 << midx);
    t = s;
    l = lvl_m;
    repeat (DIV * 3 * (rep + 1) + 4) @(posedge clk);
    #Q;
    check(nrec - base == rep + 1, "R5 transition count", nrec - base, rep + 1);
    check(active_o == 1'b0, "R5 idle after last", int'(active_o), 0);
    ep = '0;
    for (int k = 0; k <= rep; k++) begin
      iv = l ? ((hi == 0) ? 1 : hi) : ((lo == 0) ? 1 : lo);
      t  = t + iv * DIV;
      l  = ~l;
      ep = (pin & ~m) | (l ? m : '0);
      if (base + k < nrec && base + k < 256) begin
        check(rec_cyc[base + k] == t,
              (k == 0) ? ((hi == 0 || lo == 0) ? "R2/R6 first edge" : "R2 first edge")
                       : ((hi == 0 || lo == 0) ? "R4/R6 next edge" : "R4 next edge"),
              rec_cyc[base + k], t);
        check(rec_lvl[base + k] == l, "R3 level flip", int'(rec_lvl[base + k]), int'(l));
        check(rec_port[base + k] == ep, "R3 merged byte", int'(rec_port[base + k]), int'(ep));
      end
    end
    check(port_out_o == ep, "R10 output held", int'(port_out_o), int'(ep));
    lvl_m = l;
  endtask

  initial begin
    #(CLK_P * 150000);
    checks = checks + 1;
    failures = failures + 1;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    summary();
    $finish;
  end

  initial begin
    int base, s, s2, run;
    repeat (3) @(posedge clk);
    #Q;
    check(port_out_o == '0, "R1 port reset", int'(port_out_o), 0);
    check(port_we_o == 1'b0, "R1 strobe reset", int'(port_we_o), 0);
    check(active_o == 1'b0, "R1 active reset", int'(active_o), 0);
    check(level_o == 1'b0, "R1 level reset", int'(level_o), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    run = 0;
    for (int hi = 0; hi < 4; hi++) begin
      for (int li = 0; li < 3; li++) begin
        for (int rep = 0; rep < 4; rep++) begin
          run_cfg(hi, (li == 2) ? 3 : li, rep, run % PW, PW'(8'hA5 ^ (run * 37)));
          run = run + 1;
        end
      end
    end

    // R2: start raises active in the following cycle
    pulse_start(6, 6, 0, 3, 8'h0F, base, s);
    check(active_o == 1'b1, "R2 active after start", int'(active_o), 1);
    repeat (20) @(posedge clk);
    lvl_m = ~lvl_m;

    // R7: clear mid-run after the first transition
    pulse_start(5, 5, 5, 2, 8'h3C, base, s);
    repeat (5 * DIV + 1) @(posedge clk);
    #Q;
    clear_i = 1'b1;
    @(posedge clk); #Q;
    clear_i = 1'b0;
    check(active_o == 1'b0, "R7 active cleared", int'(active_o), 0);
    repeat (40) @(posedge clk);
    #Q;
    check(nrec - base == 1, "R7 no transitions after clear", nrec - base, 1);
    check(level_o == ~lvl_m, "R7 level kept", int'(level_o), int'(~lvl_m));
    lvl_m = ~lvl_m;

    // R8: simultaneous start and clear
    @(posedge clk); #Q;
    base = nrec;
    high_time_i = 8'd1; low_time_i = 8'd1; repeat_i = 8'd3;
    start_i = 1'b1; clear_i = 1'b1;
    @(posedge clk); #Q;
    start_i = 1'b0; clear_i = 1'b0;
    check(active_o == 1'b0, "R8 clear wins", int'(active_o), 0);
    repeat (20) @(posedge clk);
    #Q;
    check(nrec == base, "R8 no transitions", nrec - base, 0);
    check(level_o == lvl_m, "R8 level unchanged", int'(level_o), int'(lvl_m));

    // R9: restart while active discards the pending interval
    pulse_start(4, 4, 3, 5, 8'h81, base, s);
    repeat (3) @(posedge clk);
    pulse_start(2, 2, 0, 6, 8'h18, base, s2);
    repeat (30) @(posedge clk);
    #Q;
    check(nrec - base == 1, "R9 single transition", nrec - base, 1);
    if (nrec > base && base < 256) begin
      check(rec_cyc[base] == s2 + 2 * DIV, "R9 timing from restart", rec_cyc[base], s2 + 2 * DIV);
      check(rec_port[base] == ((8'h18 & ~8'h40) | (~lvl_m ? 8'h40 : 8'h00)),
            "R9 merged byte", int'(rec_port[base]),
            int'((8'h18 & ~8'h40) | (~lvl_m ? 8'h40 : 8'h00)));
    end
    check(active_o == 1'b0, "R9 idle afterwards", int'(active_o), 0);

    summary();
    $finish;
  end
endmodule